// File: doc/BRIEF.md
# ADC Input Scan Sequencer

This block decides which positive analog input is presented to the converter during a conversion sequence. Software can write a one-shot start bit, or a hardware event line can pulse. Either one launches a sweep that begins at a programmed base channel. The sweep then climbs one channel at a time through a programmed number of further consecutive channels. Each channel gets its own conversion request, and the select moves on only when the converter timing logic reports that the current conversion has finished.

At the end of the sweep the select falls back to the base channel and a single-cycle completion pulse is raised. While no sweep is running, the select follows the programmed base channel, so the multiplexer is already settled on the first channel before any conversion begins. The analog multiplexer, the converter and the register decoding sit outside this block. The start bit is cleared by the acknowledge pulse that this block returns when it accepts a request.

Top module: `scan_seq`

## Requirements
- R1: While reset is asserted (rst_n low), ch_sel is 0 and conv_req, start_ack, scan_busy and scan_done are all 0.
- R2: When sw_start or evt_start is high at a clock edge with scan_busy low, then after that edge scan_busy is 1, ch_sel equals base_ch, and conv_req and start_ack are each high for that one cycle.
- R3: When conv_done is high at an edge while scan_busy is 1 and ch_sel is below the last channel, ch_sel rises by exactly one after that edge and conv_req is high for the following cycle.
- R4: The last channel is base_ch + scan_cnt, as captured at the start. When conv_done is high at an edge while ch_sel equals the last channel, then after that edge scan_busy is 0, ch_sel is back to the captured base and scan_done is high for exactly one cycle.
- R5: With scan_cnt = 0, a sweep issues exactly one conversion request, on base_ch.
- R6: A start on either input while scan_busy is 1 is ignored. This includes a start in the same cycle as the final conv_done. An ignored start gives no start_ack and no conv_req, and ch_sel does not change.
- R7: conv_done while scan_busy is 0 produces no conv_req and no scan_done.
- R8: While idle with no start, ch_sel takes the value of base_ch one clock later.
- R9: If base_ch + scan_cnt exceeds 15 (4-bit channel index), the last channel is clamped to 15. The number of conversions in the sweep is then 16 - base_ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_start | input | 1 | Software start bit (held until start_ack) |
| evt_start | input | 1 | Event start pulse |
| base_ch | input | 4 | Lowest channel of the sweep |
| scan_cnt | input | 4 | Number of channels beyond the base |
| conv_done | input | 1 | Conversion finished pulse from converter timing |
| ch_sel | output | 4 | Positive input channel select |
| conv_req | output | 1 | One-cycle request to convert the selected channel |
| start_ack | output | 1 | Start accepted; clears the software start bit |
| scan_busy | output | 1 | Sweep in progress |
| scan_done | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The collision that matters is a new start request arriving on the same edge as the conversion-done that closes a sweep. The end of one sweep and the acceptance of the next would then fall in one cycle. The bench provokes this by driving the converter's done pulse by hand and raising the start bit in exactly the cycle where the last channel's done is sampled. The expected result is a scan_done pulse with no start_ack and no conv_req, followed by an idle cycle. A behavioural model that runs alongside the design confirms the same outcome on every clock.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  // Highest channel reached by a sweep, saturated at the top index.
  function automatic int unsigned scan_last_idx(input int unsigned base,
                                                input int unsigned extra,
                                                input int unsigned top);
    int unsigned sum;
    sum = base + extra;
    return (sum > top) ? top : sum;
  endfunction

  // Number of conversions a sweep will issue.
  function automatic int unsigned scan_len(input int unsigned base,
                                           input int unsigned extra,
                                           input int unsigned top);
    return scan_last_idx(base, extra, top) - base + 1;
  endfunction

endpackage

// File: rtl/scan_trigger.sv
module scan_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_start,
  input  logic evt_start,
  input  logic busy,
  output logic accept,
  output logic start_ack
);
  logic any_start;
  logic ack_q;

  assign any_start = sw_start | evt_start;
  assign accept    = any_start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= accept;
  end

  assign start_ack = ack_q;

  // R2: acknowledge is a single-cycle pulse
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ack |=> !start_ack);

  // R6: a start seen while busy is never acknowledged
  p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && any_start) |=> !start_ack);

endmodule

// File: rtl/scan_chan.sv
module scan_chan
  import scan_seq_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             advance,
  input  logic             finish,
  input  logic             busy,
  input  logic [CH_W-1:0]  base_ch,
  input  logic [CNT_W-1:0] scan_cnt,
  output logic [CH_W-1:0]  ch_sel,
  output logic             at_last
);
  localparam int unsigned TOP_CH = (1 << CH_W) - 1;

  logic [CH_W-1:0] ch_q;
  logic [CH_W-1:0] base_q;
  logic [CH_W-1:0] last_q;
  logic [CH_W-1:0] last_calc;

  assign last_calc = CH_W'(scan_last_idx(32'(base_ch), 32'(scan_cnt), TOP_CH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      base_q <= '0;
      last_q <= '0;
    end else if (accept) begin
      ch_q   <= base_ch;
      base_q <= base_ch;
      last_q <= last_calc;
    end else if (advance) begin
      ch_q <= ch_q + CH_W'(1);
    end else if (finish) begin
      ch_q <= base_q;
    end else if (!busy) begin
      ch_q <= base_ch;
    end
  end

  assign at_last = (ch_q == last_q);
  assign ch_sel  = ch_q;

  // R3: each intermediate completion moves the select up by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (ch_q == $past(ch_q) + CH_W'(1)));

  // R9: during a sweep the select stays inside [base, clamped last]
  p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ch_q >= base_q && ch_q <= last_q));

  // R4: the select returns to the captured base after the final completion
  p_return_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (ch_q == $past(base_q)));

  // R8: when idle the select tracks the base input
  p_idle_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> (ch_q == $past(base_ch)));

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic conv_done,
  input  logic at_last,
  output logic busy,
  output logic advance,
  output logic finish,
  output logic conv_req,
  output logic scan_done
);
  logic busy_q;
  logic req_q;
  logic done_q;

  assign advance = busy_q & conv_done & ~at_last;
  assign finish  = busy_q & conv_done &  at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      req_q  <= accept | advance;
      done_q <= finish;
      if (accept)      busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign conv_req  = req_q;
  assign scan_done = done_q;

  // R4: completion pulse only appears once the sweep has closed
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !busy);

  // R4: completion is a one-cycle pulse
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);

  // R7: a stray completion while idle has no effect
  p_idle_done_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && conv_done && !accept) |=> (!conv_req && !scan_done));

endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
  parameter int CH_W  = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             evt_start,
  input  logic [CH_W-1:0]  base_ch,
  input  logic [CNT_W-1:0] scan_cnt,
  input  logic             conv_done,
  output logic [CH_W-1:0]  ch_sel,
  output logic             conv_req,
  output logic             start_ack,
  output logic             scan_busy,
  output logic             scan_done
);
  logic accept;
  logic advance;
  logic finish;
  logic busy;
  logic at_last;

  scan_trigger u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_start  (sw_start),
    .evt_start (evt_start),
    .busy      (busy),
    .accept    (accept),
    .start_ack (start_ack)
  );

  scan_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .conv_done (conv_done),
    .at_last   (at_last),
    .busy      (busy),
    .advance   (advance),
    .finish    (finish),
    .conv_req  (conv_req),
    .scan_done (scan_done)
  );

  scan_chan #(.CH_W(CH_W), .CNT_W(CNT_W)) u_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .advance  (advance),
    .finish   (finish),
    .busy     (busy),
    .base_ch  (base_ch),
    .scan_cnt (scan_cnt),
    .ch_sel   (ch_sel),
    .at_last  (at_last)
  );

  assign scan_busy = busy;

  // R2: a sweep begins only with an acknowledge and a request
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_busy) |-> (start_ack && conv_req));

  // R6: no request appears without an acceptance or a step
  p_req_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> scan_busy);

endmodule

// File: tb/scan_seq_tb_top.sv
`timescale 1ns/1ps
module scan_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_start = 1'b0;
  logic       evt_start = 1'b0;
  logic [3:0] base_ch = 4'd0;
  logic [3:0] scan_cnt = 4'd0;
  logic       conv_done = 1'b0;
  logic [3:0] ch_sel;
  logic       conv_req, start_ack, scan_busy, scan_done;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  // converter stand-in: latency 0 means manual injection only
  int lat = 0;
  int pend = 0;
  bit inj_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .evt_start(evt_start),
    .base_ch(base_ch), .scan_cnt(scan_cnt), .conv_done(conv_done),
    .ch_sel(ch_sel), .conv_req(conv_req), .start_ack(start_ack),
    .scan_busy(scan_busy), .scan_done(scan_done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // converter timing stand-in, acting just after each rising edge
  always begin
    bit auto_d;
    @(posedge clk);
    #1;
    auto_d = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) auto_d = 1;
    end
    if (conv_req && lat > 0) pend = lat;
    conv_done = inj_done | auto_d;
  end

  // behavioural reference model
  int  m_ch = 0, m_base = 0, m_last = 0;
  bit  m_busy = 0, m_req = 0, m_done = 0, m_ack = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ch = 0; m_busy = 0; m_req = 0; m_done = 0; m_ack = 0;
    end else begin
      bit go;
      go = (sw_start || evt_start) && !m_busy;
      m_req = 0; m_done = 0; m_ack = go;
      if (go) begin
        m_busy = 1; m_base = base_ch; m_ch = base_ch;
        m_last = (base_ch + scan_cnt > 15) ? 15 : base_ch + scan_cnt;
        m_req = 1;
      end else if (m_busy && conv_done) begin
        if (m_ch >= m_last) begin
          m_busy = 0; m_ch = m_base; m_done = 1;
        end else begin
          m_ch++; m_req = 1;
        end
      end else if (!m_busy) begin
        m_ch = base_ch;
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3", "ch_sel", ch_sel, m_ch);
      check("R2", "conv_req", conv_req, m_req);
      check("R2", "start_ack", start_ack, m_ack);
      check("R6", "scan_busy", scan_busy, m_busy);
      check("R4", "scan_done", scan_done, m_done);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // start one sweep and count requests until completion
  task automatic sweep(input int b, input int c, input bit use_evt,
                       input int l, input string req);
    int reqs = 0;
    int exp_n;
    exp_n = ((b + c > 15) ? 15 : b + c) - b + 1;
    @(negedge clk);
    lat = l; base_ch = 4'(b); scan_cnt = 4'(c);
    if (use_evt) evt_start = 1; else sw_start = 1;
    @(negedge clk);
    evt_start = 0; sw_start = 0;
    check(req, "ack after start", start_ack, 1);
    check(req, "first channel", ch_sel, b);
    for (int i = 0; i < 400 && !scan_done; i++) begin
      if (conv_req) reqs++;
      @(negedge clk);
    end
    check(req, "conversion count", reqs, exp_n);
    check(req, "done pulse", scan_done, 1);
    check(req, "select back to base", ch_sel, b);
    @(negedge clk);
    check(req, "done one cycle", scan_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset ch_sel", ch_sel, 0);
    check("R1", "reset busy", scan_busy, 0);
    check("R1", "reset req", conv_req, 0);
    check("R1", "reset done", scan_done, 0);
    check("R1", "reset ack", start_ack, 0);
    rst_n = 1;
    @(negedge clk);

    sweep(2, 3, 0, 2, "R2");   // software start, four channels
    sweep(5, 0, 1, 1, "R5");   // event start, single conversion
    sweep(13, 6, 0, 3, "R9");  // clamped at channel 15
    sweep(0, 15, 1, 1, "R9");  // full range from channel 0

    // R8: idle select follows base one clock later
    @(negedge clk);
    base_ch = 4'd9;
    @(negedge clk);
    check("R8", "idle tracking", ch_sel, 9);

    // R7: stray completion while idle
    inj_done = 1;
    @(negedge clk);
    inj_done = 0;
    @(negedge clk);
    check("R7", "no request", conv_req, 0);
    check("R7", "no done", scan_done, 0);

    // R6: start mid-sweep is ignored (manual completions)
    lat = 0; base_ch = 4'd0; scan_cnt = 4'd4;
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
    check("R2", "manual sweep started", scan_busy, 1);
    @(negedge clk);
    evt_start = 1;
    @(negedge clk);
    evt_start = 0;
    check("R6", "ignored start no ack", start_ack, 0);
    check("R6", "ignored start no req", conv_req, 0);
    check("R6", "ignored start channel", ch_sel, 0);
    for (int k = 0; k < 4; k++) begin
      inj_done = 1;
      @(negedge clk);
      inj_done = 0;
      @(negedge clk);
      check("R3", "manual step", ch_sel, k + 1);
    end
    // final completion and a new start sampled at the same edge
    inj_done = 1;
    @(negedge clk);
    inj_done = 0;
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
    check("R6", "collision done", scan_done, 1);
    check("R6", "collision no ack", start_ack, 0);
    check("R6", "collision no req", conv_req, 0);
    check("R6", "collision idle", scan_busy, 0);
    @(negedge clk);
    check("R6", "still idle", scan_busy, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule